// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block is a slave on a three-wire serial bus: serial clock, serial data and load strobe. It assembles 24-bit configuration words and, when the load strobe rises, hands the assembled word to one of four configuration latches. The two least significant bits of the word select the latch. Each latch splits the word into fields: an integer divide value, a fraction, a fractional modulus, a reference divide value, a monitor-mux code, a fast-settle flag, control bits and a raw noise/spur word. These fields drive a fractional-N divider.

All three serial inputs are asynchronous to the system clock `clk`. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies. The modulus is double-buffered. A modulus write goes to a pending copy, and that copy becomes active only at the next integer/fraction write, so the divider never sees a half-updated ratio. If the modulus word carries its load-control flag, the same 12-bit field is written as a resync delay and both modulus copies stay as they are. Every integer/fraction write gives a one-cycle channel strobe. A range flag reports a write that is out of range, and that write is still applied. The pins are plain control and status; there is no stream interface and so no valid/ready handshake or back-pressure.

Top module: `cfg_serial_loader`

## Requirements
- R1: On each synchronised rising edge of `ser_clk_i`, `ser_data_i` is shifted into a 24-bit register MSB first. Only the last 24 bits shifted before a load are kept.
- R2: On each synchronised rising edge of `ser_load_i`, the word is routed by bits 1:0: 00 goes to the divide latch, 01 to the modulus latch, 10 to the control latch and 11 to the noise latch. The other latches keep their values.
- R3: A divide-latch write stores the fraction from bits 13:2, the integer from bits 22:14 and the fast-settle flag from bit 23.
- R4: A modulus-latch write stores the reference divide from bits 17:14 and the mux code from bits 22:20. When bit 23 is 0, bits 13:2 go to the pending modulus.
- R5: The active modulus takes the pending value at each divide-latch write and at no other time.
- R6: A modulus-latch write with bit 23 = 1 stores bits 13:2 as the resync delay and leaves the pending and active modulus unchanged. The reference divide and mux code are still updated.
- R7: A control-latch write stores bits 23:2 as raw control bits and decodes counter reset from bit 3, power-down from bit 4 and the resync multiplier from bits 15:12. A noise-latch write stores bits 23:2 as raw noise bits.
- R8: `new_chan_o` is high for exactly one `clk` cycle per divide-latch write and never for other writes.
- R9: At each divide-latch write, `range_err_o` is set to 1 if the integer is below 31, the newly active modulus is below 2, or the fraction is at or above that modulus, and to 0 otherwise. All fields are stored regardless.
- R10: After reset, every output is 0.
- R11: Loading a word does not clear the shift register, so a second load strobe with no serial clocks in between applies the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_i | input | 1 | Load strobe; rising edge applies the word |
| frac_o | output | 12 | Fraction |
| int_o | output | 9 | Integer divide value |
| fastlock_o | output | 1 | Fast-settle flag |
| mod_active_o | output | 12 | Active modulus |
| mod_pending_o | output | 12 | Pending modulus |
| resync_dly_o | output | 12 | Resync delay |
| ref_div_o | output | 4 | Reference divide value |
| mux_sel_o | output | 3 | Monitor mux code |
| counter_rst_o | output | 1 | Counter reset control |
| power_down_o | output | 1 | Power-down control |
| resync_mult_o | output | 4 | Resync multiplier (0 = disabled) |
| ctrl_bits_o | output | 22 | Raw control latch bits 23:2 |
| noise_bits_o | output | 22 | Raw noise latch bits 23:2 |
| new_chan_o | output | 1 | One-cycle strobe per divide-latch write |
| range_err_o | output | 1 | Last divide-latch write was out of range |

## Verification
The assertions assume that each serial input holds its level for at least two `clk` cycles between transitions. Under that condition every synchronised edge is seen once and the data bit is settled when the serial clock edge is detected. They also assume that a load strobe does not rise in the same cycle as a serial clock edge. The bench keeps each serial phase for four system clocks and sets data a full phase before the clock rises. It separates the load strobe from the last serial clock edge by several cycles and waits for the decode pipeline to drain before it samples any output.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W  = 24;
  localparam int SEL_W   = 2;
  localparam int FRAC_W  = 12;
  localparam int INT_W   = 9;
  localparam int MOD_W   = 12;
  localparam int REFD_W  = 4;
  localparam int MUX_W   = 3;
  localparam int MULT_W  = 4;
  localparam int RAW_W   = WORD_W - SEL_W;

  // field positions (low bit)
  localparam int FRAC_LO = 2;
  localparam int INT_LO  = FRAC_LO + FRAC_W;
  localparam int FLAG_B  = WORD_W - 1;
  localparam int MOD_LO  = 2;
  localparam int REFD_LO = MOD_LO + MOD_W;
  localparam int MUX_LO  = 20;
  localparam int CRST_B  = 3;
  localparam int PDN_B   = 4;
  localparam int MULT_LO = 12;

  localparam int INT_MIN = 31;
  localparam int MOD_MIN = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIV   = 2'b00,
    SEL_MOD   = 2'b01,
    SEL_CTRL  = 2'b10,
    SEL_NOISE = 2'b11
  } latch_sel_e;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int  STAGES = 2,
  parameter bit  EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sig_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  generate
    if (EDGE) begin : g_rise
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
      end
      assign sig_o = chain_q[STAGES-1] & ~prev_q;

      // R2: a detected rising edge cannot repeat on the next cycle
      a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        sig_o |=> !sig_o);
    end else begin : g_level
      assign sig_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic [WORD_W-1:0] sr_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
      vld_q <= load_i;
    end
  end

  assign word_o     = sr_q;
  assign word_vld_o = vld_q;

  // R1: the register moves only on a serial clock edge
  a_r1_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(sr_q));

  // R11: a load leaves the assembled word untouched
  a_r11_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/cfgld_decode.sv
module cfgld_decode
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_vld_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [INT_W-1:0]  int_o,
  output logic              fastlock_o,
  output logic [MOD_W-1:0]  mod_active_o,
  output logic [MOD_W-1:0]  mod_pending_o,
  output logic [MOD_W-1:0]  resync_dly_o,
  output logic [REFD_W-1:0] ref_div_o,
  output logic [MUX_W-1:0]  mux_sel_o,
  output logic              counter_rst_o,
  output logic              power_down_o,
  output logic [MULT_W-1:0] resync_mult_o,
  output logic [RAW_W-1:0]  ctrl_bits_o,
  output logic [RAW_W-1:0]  noise_bits_o,
  output logic              new_chan_o,
  output logic              range_err_o
);
  localparam logic [INT_W-1:0] INT_MIN_V = INT_W'(INT_MIN);
  localparam logic [MOD_W-1:0] MOD_MIN_V = MOD_W'(MOD_MIN);

  latch_sel_e               sel;
  logic [FRAC_W-1:0]        w_frac;
  logic [INT_W-1:0]         w_int;
  logic [MOD_W-1:0]         w_mod;
  logic                     w_flag;
  logic                     bad_write;

  always_comb begin
    sel       = latch_sel_e'(word_i[SEL_W-1:0]);
    w_frac    = word_i[FRAC_LO +: FRAC_W];
    w_int     = word_i[INT_LO  +: INT_W];
    w_mod     = word_i[MOD_LO  +: MOD_W];
    w_flag    = word_i[FLAG_B];
    bad_write = (w_int < INT_MIN_V) || (mod_pending_o < MOD_MIN_V) ||
                ({{(MOD_W-FRAC_W){1'b0}}, w_frac} >= mod_pending_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_o        <= '0;
      int_o         <= '0;
      fastlock_o    <= 1'b0;
      mod_active_o  <= '0;
      mod_pending_o <= '0;
      resync_dly_o  <= '0;
      ref_div_o     <= '0;
      mux_sel_o     <= '0;
      counter_rst_o <= 1'b0;
      power_down_o  <= 1'b0;
      resync_mult_o <= '0;
      ctrl_bits_o   <= '0;
      noise_bits_o  <= '0;
      new_chan_o    <= 1'b0;
      range_err_o   <= 1'b0;
    end else begin
      new_chan_o <= 1'b0;
      if (word_vld_i) begin
        unique case (sel)
          SEL_DIV: begin
            frac_o       <= w_frac;
            int_o        <= w_int;
            fastlock_o   <= w_flag;
            mod_active_o <= mod_pending_o;
            new_chan_o   <= 1'b1;
            range_err_o  <= bad_write;
          end
          SEL_MOD: begin
            ref_div_o <= word_i[REFD_LO +: REFD_W];
            mux_sel_o <= word_i[MUX_LO  +: MUX_W];
            if (w_flag) resync_dly_o  <= w_mod;
            else        mod_pending_o <= w_mod;
          end
          SEL_CTRL: begin
            ctrl_bits_o   <= word_i[WORD_W-1:SEL_W];
            counter_rst_o <= word_i[CRST_B];
            power_down_o  <= word_i[PDN_B];
            resync_mult_o <= word_i[MULT_LO +: MULT_W];
          end
          default: begin
            noise_bits_o <= word_i[WORD_W-1:SEL_W];
          end
        endcase
      end
    end
  end

  // R5: the active modulus moves only together with the channel strobe
  a_r5_mod_on_chan: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_active_o) |-> new_chan_o);

  // R6: a resync-delay write freezes both modulus copies
  a_r6_resync_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && sel == SEL_MOD && w_flag) |=>
      ($stable(mod_pending_o) && $stable(mod_active_o)));

  // R8: the channel strobe lasts one cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    new_chan_o |=> !new_chan_o);

  // R9: a low integer always raises the range flag
  a_r9_int_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (new_chan_o && int_o < INT_MIN_V) |-> range_err_o);

  // R9: fraction at or above the active modulus raises the flag
  a_r9_frac_high_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (new_chan_o && {{(MOD_W-FRAC_W){1'b0}}, frac_o} >= mod_active_o) |-> range_err_o);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_load_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [INT_W-1:0]  int_o,
  output logic              fastlock_o,
  output logic [MOD_W-1:0]  mod_active_o,
  output logic [MOD_W-1:0]  mod_pending_o,
  output logic [MOD_W-1:0]  resync_dly_o,
  output logic [REFD_W-1:0] ref_div_o,
  output logic [MUX_W-1:0]  mux_sel_o,
  output logic              counter_rst_o,
  output logic              power_down_o,
  output logic [MULT_W-1:0] resync_mult_o,
  output logic [RAW_W-1:0]  ctrl_bits_o,
  output logic [RAW_W-1:0]  noise_bits_o,
  output logic              new_chan_o,
  output logic              range_err_o
);
  logic              sclk_rise;
  logic              data_lvl;
  logic              load_rise;
  logic [WORD_W-1:0] word;
  logic              word_vld;

  cfgld_sync #(.STAGES(2), .EDGE(1'b1)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i), .sig_o(sclk_rise));
  cfgld_sync #(.STAGES(2), .EDGE(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .async_i(ser_data_i), .sig_o(data_lvl));
  cfgld_sync #(.STAGES(2), .EDGE(1'b1)) u_sync_ld (
    .clk(clk), .rst_n(rst_n), .async_i(ser_load_i), .sig_o(load_rise));

  cfgld_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(sclk_rise), .bit_i(data_lvl),
    .load_i(load_rise), .word_o(word), .word_vld_o(word_vld));

  cfgld_decode u_decode (
    .clk(clk), .rst_n(rst_n), .word_i(word), .word_vld_i(word_vld),
    .frac_o(frac_o), .int_o(int_o), .fastlock_o(fastlock_o),
    .mod_active_o(mod_active_o), .mod_pending_o(mod_pending_o),
    .resync_dly_o(resync_dly_o), .ref_div_o(ref_div_o),
    .mux_sel_o(mux_sel_o), .counter_rst_o(counter_rst_o),
    .power_down_o(power_down_o), .resync_mult_o(resync_mult_o),
    .ctrl_bits_o(ctrl_bits_o), .noise_bits_o(noise_bits_o),
    .new_chan_o(new_chan_o), .range_err_o(range_err_o));
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [11:0] frac_o, mod_active_o, mod_pending_o, resync_dly_o;
  logic [8:0]  int_o;
  logic        fastlock_o, counter_rst_o, power_down_o, new_chan_o, range_err_o;
  logic [3:0]  ref_div_o, resync_mult_o;
  logic [2:0]  mux_sel_o;
  logic [21:0] ctrl_bits_o, noise_bits_o;

  always #2 clk = ~clk;

  cfg_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .ser_load_i(ser_load), .frac_o(frac_o), .int_o(int_o), .fastlock_o(fastlock_o),
    .mod_active_o(mod_active_o), .mod_pending_o(mod_pending_o),
    .resync_dly_o(resync_dly_o), .ref_div_o(ref_div_o), .mux_sel_o(mux_sel_o),
    .counter_rst_o(counter_rst_o), .power_down_o(power_down_o),
    .resync_mult_o(resync_mult_o), .ctrl_bits_o(ctrl_bits_o),
    .noise_bits_o(noise_bits_o), .new_chan_o(new_chan_o), .range_err_o(range_err_o));

  int vectors = 0, misses = 0, strobe_hi = 0;
  logic [11:0] m_frac, m_mact, m_mpend, m_rsd;
  logic [8:0]  m_int;
  logic        m_fl, m_crst, m_pdn, m_err;
  logic [3:0]  m_ref, m_mult;
  logic [2:0]  m_mux;
  logic [21:0] m_ctrl, m_noise;
  logic [23:0] last_word;

  always @(negedge clk) if (new_chan_o) strobe_hi++;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic phase();
    repeat (4) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      phase();
      ser_clk = 1'b1;
      phase();
      ser_clk = 1'b0;
    end
  endtask

  // model update from the requirements, then load pulse
  task automatic apply_load(logic [23:0] w);
    case (w[1:0])
      2'b00: begin // R3, R5, R9
        m_frac = w[13:2]; m_int = w[22:14]; m_fl = w[23]; m_mact = m_mpend;
        m_err = (m_int < 31) || (m_mact < 2) || (m_frac >= m_mact);
      end
      2'b01: begin // R4, R6
        m_ref = w[17:14]; m_mux = w[22:20];
        if (w[23]) m_rsd = w[13:2]; else m_mpend = w[13:2];
      end
      2'b10: begin // R7
        m_ctrl = w[23:2]; m_crst = w[3]; m_pdn = w[4]; m_mult = w[15:12];
      end
      default: m_noise = w[23:2];
    endcase
    phase();
    ser_load = 1'b1;
    phase();
    ser_load = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(string req);
    chk(req, "frac", 32'(frac_o), 32'(m_frac));
    chk(req, "int", 32'(int_o), 32'(m_int));
    chk(req, "fastlock", 32'(fastlock_o), 32'(m_fl));
    chk(req, "mod_active", 32'(mod_active_o), 32'(m_mact));
    chk(req, "mod_pending", 32'(mod_pending_o), 32'(m_mpend));
    chk(req, "resync_dly", 32'(resync_dly_o), 32'(m_rsd));
    chk(req, "ref_div", 32'(ref_div_o), 32'(m_ref));
    chk(req, "mux_sel", 32'(mux_sel_o), 32'(m_mux));
    chk(req, "counter_rst", 32'(counter_rst_o), 32'(m_crst));
    chk(req, "power_down", 32'(power_down_o), 32'(m_pdn));
    chk(req, "resync_mult", 32'(resync_mult_o), 32'(m_mult));
    chk(req, "ctrl_bits", 32'(ctrl_bits_o), 32'(m_ctrl));
    chk(req, "noise_bits", 32'(noise_bits_o), 32'(m_noise));
    chk("R9", "range_err", 32'(range_err_o), 32'(m_err));
  endtask

  task automatic write_word(logic [23:0] w, string req);
    int s0;
    s0 = strobe_hi;
    shift_bits(32'(w), 24);
    last_word = w;
    apply_load(w);
    check_all(req);
    chk("R8", "strobe cycles", 32'(strobe_hi - s0), (w[1:0] == 2'b00) ? 32'd1 : 32'd0);
  endtask

  function automatic logic [23:0] div_word(logic fl, logic [8:0] iv, logic [11:0] fr);
    return {fl, iv, fr, 2'b00};
  endfunction
  function automatic logic [23:0] mod_word(logic lc, logic [2:0] mx, logic [3:0] rd, logic [11:0] md);
    return {lc, mx, 2'b00, rd, md, 2'b01};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL R8 watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [11:0] mods [6]  = '{12'd0, 12'd1, 12'd2, 12'd3, 12'd130, 12'd4095};
    logic [8:0]  ints [5]  = '{9'd0, 9'd30, 9'd31, 9'd200, 9'd511};
    m_frac = '0; m_mact = '0; m_mpend = '0; m_rsd = '0; m_int = '0; m_fl = 0;
    m_crst = 0; m_pdn = 0; m_err = 0; m_ref = '0; m_mult = '0; m_mux = '0;
    m_ctrl = '0; m_noise = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R10");
    chk("R10", "new_chan", 32'(new_chan_o), 32'd0);

    // R2/R7: control and noise latches, no effect on others
    write_word(24'hA5F31A, "R7");
    write_word(24'h5A0CE7, "R7");
    write_word(24'h000012, "R2");

    // R4/R5/R6 and R3/R9 sweep
    foreach (mods[a]) begin
      write_word(mod_word(1'b0, 3'(a), 4'(a + 1), mods[a]), "R4");
      write_word(mod_word(1'b1, 3'(5 - a), 4'(15 - a), 12'(mods[a] ^ 12'h5A5)), "R6");
      foreach (ints[b]) begin
        logic [11:0] fr [4];
        fr = '{12'd0, 12'(mods[a] - 1), mods[a], 12'd4095};
        foreach (fr[c]) write_word(div_word(1'(b + c), ints[b], fr[c]), "R5");
      end
    end

    // R1: surplus leading bits are dropped
    shift_bits(32'hF, 4);
    write_word(div_word(1'b1, 9'd77, 12'd9), "R1");

    // R11: second load with no serial clocks reapplies the word
    begin
      int s0;
      s0 = strobe_hi;
      apply_load(last_word);
      check_all("R11");
      chk("R11", "strobe cycles", 32'(strobe_hi - s0), 32'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule